// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets two processors, a host and a subsystem core, pass short messages to each other through a shared register window. It holds eight one-way channels. Each channel stores a 31-bit message identifier, four 32-bit payload words and two status flags. A sender fills the payload, then writes the control word with its top bit set. That write posts the message: it marks the channel busy and raises its pending-interrupt flag.

The receiver reads the message and then acknowledges it by writing ones to the status flags. Until that acknowledge the channel stays busy, and the sender polls the busy flag to learn when the channel is free again. A read-only summary register collects the two flags of every channel in one word. A mask register holds one byte of per-channel masks for each processor. The two level-sensitive interrupt outputs are built from the pending flags and these masks.

The register bus is a plain 32-bit request interface. A write takes one cycle. Read data appears on the cycle after the read request and holds until the next read.

Top module: `mbox_hub`

## Requirements
- R1: After reset, every identifier, payload word and status flag is zero, and both interrupt outputs are low.
- R2: Channel n occupies 24 bytes at byte address 24*n. Its word at offset 0 is the control word. A write to it stores bits 30:0 as the identifier. A read returns the identifier with bit 31 as zero.
- R3: Offsets 4, 8, 12 and 16 of a channel are four payload words that can be read and written in full. They keep their value after an acknowledge.
- R4: A control write with bit 31 set makes the channel's status word (offset 20) read bit 0 (busy) = 1 and bit 1 (pending interrupt) = 1. Status bits 31:2 read as zero.
- R5: A status write clears busy if wdata bit 0 is 1 and clears the pending flag if wdata bit 1 is 1. Each flag clears independently. A written 0 leaves its flag unchanged.
- R6: A control write with bit 31 clear updates only the identifier and leaves both flags unchanged.
- R7: The summary register at 0xC0 is read-only. It holds channel n's busy flag at bit 2n and its pending flag at bit 2n+1. Bits 31:16 read as zero, and writes to it have no effect.
- R8: The mask register at 0x100 stores bits 15:0 and reads bits 31:16 as zero. It resets to 0xFFFF.
- R9: host_irq_o is high exactly when some channel n has its pending flag set and mask bit n clear. sub_irq_o works the same way using mask bit 8+n. A mask write takes effect on the next cycle.
- R10: A trigger write to a channel that is already busy is accepted. It sets the pending flag again and stores the new identifier.
- R11: rdata_o shows the addressed register on the cycle after a read request and holds its value when there is no read. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| host_irq_o | output | 1 | Level interrupt toward the host processor |
| sub_irq_o | output | 1 | Level interrupt toward the subsystem processor |

## Verification
The bench acknowledges the busy and pending flags separately and with zero bits. A design that cleared both flags on any status write, or that treated a written 0 as a clear, would free the channel early or drop the interrupt. It re-triggers a channel that is still busy; a design that ignored such writes would lose the second identifier and the refreshed pending flag. It sweeps the mask bytes per processor. A swapped byte lane, or an inverted mask polarity, sends the interrupt to the wrong core or leaves it stuck. It also checks the summary bit pairs against the per-channel flags, so pairs in the wrong order or shifted by a channel are caught.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int DW = 32;
  localparam int TRIG_BIT = DW - 1;
  localparam int ST_BUSY  = 0;
  localparam int ST_PEND  = 1;
  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int PAY_WORDS = 4,
  localparam int CH_WORDS = PAY_WORDS + 2,
  localparam int SEL_W    = $clog2(CH_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  word_t            wdata_i,
  output word_t            rdata_o,
  output logic             busy_o,
  output logic             pend_o
);
  localparam int SEL_STAT = CH_WORDS - 1;

  logic [DW-2:0]               id_q;
  word_t [PAY_WORDS-1:0]       pay_q;
  logic                        busy_q, pend_q;
  logic                        wr_ctrl, wr_stat;

  assign wr_ctrl = wr_i && (sel_i == '0);
  assign wr_stat = wr_i && (sel_i == SEL_W'(SEL_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        id_q <= wdata_i[DW-2:0];
        if (wdata_i[TRIG_BIT]) begin
          busy_q <= 1'b1;
          pend_q <= 1'b1;
        end
      end
      if (wr_stat) begin
        if (wdata_i[ST_BUSY]) busy_q <= 1'b0;
        if (wdata_i[ST_PEND]) pend_q <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < PAY_WORDS; p++) begin : g_pay
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 pay_q[p] <= '0;
      else if (wr_i && sel_i == SEL_W'(p + 1))     pay_q[p] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == '0) begin
      rdata_o = {1'b0, id_q};
    end else if (sel_i == SEL_W'(SEL_STAT)) begin
      rdata_o[ST_BUSY] = busy_q;
      rdata_o[ST_PEND] = pend_q;
    end else begin
      for (int p = 0; p < PAY_WORDS; p++)
        if (sel_i == SEL_W'(p + 1)) rdata_o = pay_q[p];
    end
  end

  assign busy_o = busy_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/mbox_irq_route.sv
module mbox_irq_route #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0]   pend_i,
  input  logic [2*N_CH-1:0] mask_i,
  output logic              host_irq_o,
  output logic              sub_irq_o
);
  always_comb begin
    host_irq_o = 1'b0;
    sub_irq_o  = 1'b0;
    for (int n = 0; n < N_CH; n++) begin
      host_irq_o = host_irq_o | (pend_i[n] & ~mask_i[n]);
      sub_irq_o  = sub_irq_o  | (pend_i[n] & ~mask_i[N_CH+n]);
    end
  end
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
  import mbox_pkg::*;
#(
  parameter int N_CH      = 8,
  parameter int PAY_WORDS = 4,
  parameter int ADDR_W    = 9,
  parameter int SUM_OFS   = 'hC0,
  parameter int MASK_OFS  = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              host_irq_o,
  output logic              sub_irq_o
);
  localparam int CH_WORDS = PAY_WORDS + 2;
  localparam int CH_BYTES = CH_WORDS * 4;
  localparam int SEL_W    = $clog2(CH_WORDS);

  logic [N_CH-1:0]   hit, busy_w, pend_w;
  word_t             ch_rd [N_CH];
  logic [2*N_CH-1:0] sum_w, mask_q;
  word_t             rd_next, rdata_q;
  logic              wr_mask;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic [ADDR_W-1:0] off;
    assign off    = addr_i - ADDR_W'(n * CH_BYTES);
    assign hit[n] = off < ADDR_W'(CH_BYTES);

    mbox_chan #(.PAY_WORDS(PAY_WORDS)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (req_i && we_i && hit[n]),
      .sel_i   (off[SEL_W+1:2]),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[n]),
      .busy_o  (busy_w[n]),
      .pend_o  (pend_w[n])
    );

    assign sum_w[2*n]   = busy_w[n];
    assign sum_w[2*n+1] = pend_w[n];
  end

  assign wr_mask = req_i && we_i && (addr_i == ADDR_W'(MASK_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (wr_mask) mask_q <= wdata_i[2*N_CH-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(SUM_OFS))       rd_next = DW'(sum_w);
    else if (addr_i == ADDR_W'(MASK_OFS)) rd_next = DW'(mask_q);
    else
      for (int n = 0; n < N_CH; n++)
        if (hit[n]) rd_next = rd_next | ch_rd[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  mbox_irq_route #(.N_CH(N_CH)) u_route (
    .pend_i     (pend_w),
    .mask_i     (mask_q),
    .host_irq_o (host_irq_o),
    .sub_irq_o  (sub_irq_o)
  );
endmodule

// File: rtl/mbox_hub_chk.sv
module mbox_hub_chk #(
  parameter int N_CH     = 8,
  parameter int ADDR_W   = 9,
  parameter int CH_BYTES = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              trig_i,
  input logic [1:0]        clr_i,
  input logic [31:0]       rdata_o,
  input logic              host_irq_o,
  input logic              sub_irq_o,
  input logic [N_CH-1:0]   busy_w,
  input logic [N_CH-1:0]   pend_w,
  input logic [2*N_CH-1:0] mask_q
);
  for (genvar n = 0; n < N_CH; n++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(n * CH_BYTES);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(n * CH_BYTES + CH_BYTES - 4);

    AST_TRIG_SETS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == CTRL_A && trig_i) |=> (busy_w[n] && pend_w[n])); // R4

    AST_ACK_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == STAT_A && clr_i[1]) |=> !pend_w[n]); // R5

    AST_ACK_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == STAT_A && clr_i[0]) |=> !busy_w[n]); // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && we_i && (addr_i == STAT_A || (addr_i == CTRL_A && trig_i)))
      |=> ($stable(busy_w[n]) && $stable(pend_w[n]))); // R6
  end

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R11

  AST_QUIET_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w == '0) |-> (!host_irq_o && !sub_irq_o)); // R9

  AST_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> (!host_irq_o && !sub_irq_o)); // R9
endmodule

bind mbox_hub mbox_hub_chk #(
  .N_CH(N_CH), .ADDR_W(ADDR_W), .CH_BYTES(CH_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .trig_i     (wdata_i[31]),
  .clr_i      (wdata_i[1:0]),
  .rdata_o    (rdata_o),
  .host_irq_o (host_irq_o),
  .sub_irq_o  (sub_irq_o),
  .busy_w     (busy_w),
  .pend_w     (pend_w),
  .mask_q     (mask_q)
);

// File: tb/mbox_hub_tb.sv
`timescale 1ns/1ps
module mbox_hub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        host_irq, sub_irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [30:0] m_id   [8];
  logic [31:0] m_pay  [8][4];
  logic [7:0]  m_busy, m_pend;
  logic [15:0] m_mask;

  always #10 clk = ~clk;

  mbox_hub u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .host_irq_o(host_irq), .sub_irq_o(sub_irq)
  );

  function automatic logic [31:0] exp_rd(input logic [8:0] a);
    logic [31:0] r = '0;
    int ch, w;
    if (a == 9'h0C0) begin
      for (int n = 0; n < 8; n++) begin
        r[2*n]   = m_busy[n];
        r[2*n+1] = m_pend[n];
      end
    end else if (a == 9'h100) begin
      r = {16'h0, m_mask};
    end else if (a < 9'h0C0) begin
      ch = int'(a) / 24;
      w  = (int'(a) % 24) / 4;
      if (w == 0)      r = {1'b0, m_id[ch]};
      else if (w == 5) r = {30'h0, m_pend[ch], m_busy[ch]};
      else             r = m_pay[ch][w-1];
    end
    return r;
  endfunction

  function automatic logic exp_host();
    return |(m_pend & ~m_mask[7:0]);
  endfunction

  function automatic logic exp_sub();
    return |(m_pend & ~m_mask[15:8]);
  endfunction

  task automatic model_wr(input logic [8:0] a, input logic [31:0] d);
    int ch, w;
    if (a == 9'h100) m_mask = d[15:0];
    else if (a < 9'h0C0) begin
      ch = int'(a) / 24;
      w  = (int'(a) % 24) / 4;
      if (w == 0) begin
        m_id[ch] = d[30:0];
        if (d[31]) begin m_busy[ch] = 1'b1; m_pend[ch] = 1'b1; end
      end else if (w == 5) begin
        if (d[0]) m_busy[ch] = 1'b0;
        if (d[1]) m_pend[ch] = 1'b0;
      end else m_pay[ch][w-1] = d;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag);
    chk({tag, " host irq"}, {31'h0, host_irq}, {31'h0, exp_host()});
    chk({tag, " sub irq"},  {31'h0, sub_irq},  {31'h0, exp_sub()});
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    chk(tag, rdata, exp_rd(a));
  endtask

  function automatic logic [8:0] ch_addr(input int ch, input int w);
    return 9'(ch * 24 + w * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int c = 0; c < 8; c++) begin
      m_id[c] = '0;
      for (int p = 0; p < 4; p++) m_pay[c][p] = '0;
    end
    m_busy = '0; m_pend = '0; m_mask = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R8 reset state
    chk_irq("R1 reset");
    rd(9'h100, "R8 mask reset");
    rd(9'h0C0, "R1 summary reset");
    for (int c = 0; c < 8; c++) rd(ch_addr(c, 5), "R1 status reset");
    rd(ch_addr(7, 2), "R1 payload reset");

    // R2 / R3 storage
    wr(ch_addr(3, 0), 32'h7FFF_FFFF);
    rd(ch_addr(3, 0), "R2 id max, no trigger");
    rd(ch_addr(3, 5), "R6 no trigger keeps flags clear");
    for (int p = 1; p <= 4; p++) wr(ch_addr(3, p), 32'hA5A5_0000 + 32'(p));
    for (int p = 1; p <= 4; p++) rd(ch_addr(3, p), "R3 payload");

    // R4 / R7 post a message, still masked
    wr(ch_addr(3, 0), 32'h8000_1234);
    rd(ch_addr(3, 5), "R4 status after trigger");
    rd(ch_addr(3, 0), "R2 trigger bit reads zero");
    rd(9'h0C0, "R7 summary pair");
    chk_irq("R9 all masked");

    // R9 per-processor routing
    wr(9'h100, 32'hFFFF_FFF7);
    chk_irq("R9 host unmasked");
    rd(9'h100, "R8 upper bits zero");
    wr(9'h100, 32'h0000_F7FF);
    chk_irq("R9 sub unmasked");
    wr(9'h100, 32'h0000_FEFE);
    chk_irq("R9 other channel unmasked");
    wr(9'h100, 32'h0000_F7F7);

    // R7 summary is read-only
    wr(9'h0C0, 32'hFFFF_FFFF);
    rd(9'h0C0, "R7 write ignored");

    // R5 acknowledge
    wr(ch_addr(3, 5), 32'h0);
    rd(ch_addr(3, 5), "R5 zero write no effect");
    wr(ch_addr(3, 5), 32'h2);
    rd(ch_addr(3, 5), "R5 pending clear only");
    chk_irq("R5 irq drops after ack");
    wr(ch_addr(3, 0), 32'h8000_0055);
    wr(ch_addr(3, 5), 32'h1);
    rd(ch_addr(3, 5), "R5 busy clear only");
    chk_irq("R5 irq stays with busy cleared");
    wr(ch_addr(3, 5), 32'h3);
    rd(9'h0C0, "R5 both clear");
    rd(ch_addr(3, 1), "R3 payload kept after ack");

    // R10 retrigger busy channel
    wr(ch_addr(0, 0), 32'h8000_0001);
    wr(ch_addr(0, 5), 32'h2);
    wr(ch_addr(0, 0), 32'h8000_0002);
    rd(ch_addr(0, 5), "R10 retrigger sets pending");
    rd(ch_addr(0, 0), "R10 new id");

    // R11 unmapped and hold
    rd(9'h0C4, "R11 unmapped zero");
    rd(9'h1FC, "R11 unmapped high zero");
    rd(ch_addr(0, 0), "R11 read");
    wr(ch_addr(0, 0), 32'h0000_0777);
    chk("R11 rdata holds across write", rdata, 32'h0000_0002);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 9));
      int c  = int'($urandom_range(0, 7));
      logic [31:0] d = $urandom;
      if (op < 2)       wr(ch_addr(c, 0), ($urandom_range(0, 2) == 0) ? {1'b1, d[30:0]} : {1'b0, d[30:0]});
      else if (op < 3)  wr(ch_addr(c, int'($urandom_range(1, 4))), d);
      else if (op < 4)  wr(ch_addr(c, 5), {30'h0, d[1:0]});
      else if (op < 5)  wr(9'h100, d);
      else if (op < 8)  rd(ch_addr(c, int'($urandom_range(0, 5))), "R2 R3 R4 random read");
      else if (op < 9)  rd(9'h0C0, "R7 random summary");
      else              rd(9'h100, "R8 random mask");
      chk_irq("R9 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule